// File: doc/BRIEF.md
# Triggered Event Code Sequencer

This block replays short lists of 8-bit event codes onto a single event stream, one code per clock slot. Each of its sequencers owns a small memory of entries; an entry pairs a timestamp, counted in prescaled clock ticks, with a code. Once armed by its chosen trigger, a sequencer starts its own time counter from zero and sends each entry as soon as the counter reaches that entry's timestamp. Two codes have special meaning. A null code uses its slot and sends nothing. An end code finishes the list: the sequencer then goes idle, or it restarts the list at once if recycling is enabled.

Each sequencer has its own trigger source: a per-sequencer software strobe, a shared external input, a shared counter tick, or the line-synchronisation path. The line path takes an asynchronous mains-rate input and brings it into the clock domain with a two-stage synchroniser. A programmable divider (ratio 1 to 256) then thins the rising edges, and a phase delay follows, set in steps of a fixed number of clock cycles (one step stands for 0.1 ms at the target clock). When several sequencers emit in the same slot, a fixed priority picks which code goes onto the merged stream.

Top module: `evseq_top`

## Requirements
- R1: After reset the merged event output is 0x00, every busy flag is low and the line-sync tick is low.
- R2: Each sequencer's 2-bit trigger select picks its start source: 0 = its software strobe, 1 = external input, 2 = counter tick, 3 = line-sync tick. Strobes on the sources that are not selected do not start it.
- R3: With a prescale setting p (rate p+1) and a trigger sampled at clock edge T, an entry with timestamp k is emitted in the cycle after edge T+1+k*(p+1), provided that earlier entries have already been sent.
- R4: An entry whose code is 0x00 is consumed when it falls due, but the output stays 0x00 in that slot. The code 0x7F never appears on the output.
- R5: An entry with code 0x7F and recycle low stops the sequencer: its busy flag drops one edge after the entry falls due, and nothing is emitted again until a new trigger arrives.
- R6: An entry with code 0x7F and recycle high restarts the list at entry 0 with time zero, behaving like a trigger at that edge. The busy flag stays high.
- R7: A trigger that arrives while a sequencer is busy has no effect on its pointer or its time.
- R8: The line divider with setting d produces one divided pulse for every d+1 synchronised rising edges of line_in.
- R9: With phase setting s, line_sync_tick is high for exactly one cycle, after clock edge E+3+s*STEP_CYCLES, where E is the first edge that samples line_in high on the rising edge that completes a divide count.
- R10: When several sequencers emit in the same slot, the lowest-indexed one drives the merged output and the others' codes are dropped.
- R11: When the last memory entry has been sent and it is not an end code, the sequencer acts as if it had reached an end code (it stops, or it restarts if recycle is high).
- R12: The sequencers run independently of each other, each with its own select, prescale, recycle and memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous mains-rate pulse input |
| ext_trig | input | 1 | Synchronous external trigger strobe |
| cnt_tick | input | 1 | Synchronous counter-output strobe |
| sw_trig | input | NSEQ | Software start strobe, one bit per sequencer |
| trig_sel | input | 2*NSEQ | Trigger select, 2 bits per sequencer |
| recycle | input | NSEQ | Restart on end, one bit per sequencer |
| presc_m1 | input | NSEQ*PW | Prescale setting minus one, per sequencer |
| ls_div_m1 | input | 8 | Line divider ratio minus one |
| ls_phase | input | 8 | Line phase delay in steps |
| ram_we | input | NSEQ | Memory write enable, one bit per sequencer |
| ram_addr | input | $clog2(DEPTH) | Memory write address |
| ram_ts | input | 32 | Entry timestamp to write |
| ram_code | input | 8 | Entry code to write |
| ev_code | output | 8 | Merged event stream, 0x00 when the slot is empty |
| seq_busy | output | NSEQ | Sequencer running flags |
| line_sync_tick | output | 1 | Delayed line-sync trigger pulse |

## Verification
The case hardest to reach from the ports is the line-sync trigger. Its timing depends on an asynchronous edge, passes through three synchroniser and edge-detect registers, a divide count spread across several mains pulses, and a phase countdown, and only then starts a sequencer. The bench makes the phase step only a few cycles long and drives clean line pulses at known cycles, recording each one's sampling edge. It then checks that no tick appears before the divide count completes, and that both the tick and the code emitted after it land on the computed cycle. A retrigger in the middle of a run is placed so that, if it were accepted, it would visibly shift a later timestamped code.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
  localparam int CODE_W = 8;
  localparam int TS_W   = 32;

  localparam logic [CODE_W-1:0] CODE_NULL = 8'h00;
  localparam logic [CODE_W-1:0] CODE_END  = 8'h7F;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [CODE_W-1:0] code;
  } seq_entry_t;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_LINE = 2'd3
  } trig_src_e;

  // Number of clock cycles the phase delay lasts for a given step setting.
  function automatic logic [TS_W-1:0] phase_cycles(input logic [7:0] steps,
                                                   input int unsigned step_cycles);
    return TS_W'(steps) * TS_W'(step_cycles);
  endfunction

  // An entry is due once the running time has reached its stamp.
  function automatic logic entry_due(input logic [TS_W-1:0] now,
                                     input logic [TS_W-1:0] stamp);
    return now >= stamp;
  endfunction
endpackage

// File: rtl/evseq_linesync.sv
module evseq_linesync #(
  parameter int unsigned STEP_CYCLES = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic [7:0] div_m1,
  input  logic [7:0] phase,
  output logic       tick_o
);
  import evseq_pkg::*;

  localparam int unsigned PH_MAX = 255 * STEP_CYCLES;
  localparam int PH_W = $clog2(PH_MAX + 1);

  logic [2:0]      sync_q;
  logic            rise;
  logic [7:0]      div_cnt;
  logic            div_hit;
  logic            active_q;
  logic [PH_W-1:0] ph_cnt;
  logic [TS_W-1:0] ph_load_full;

  // Two synchroniser stages, then a history stage for edge detection.
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], line_in};
  end

  assign rise    = sync_q[1] & ~sync_q[2];
  assign div_hit = rise && (div_cnt == div_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else if (rise) div_cnt <= div_hit ? 8'd0 : div_cnt + 8'd1;
  end

  assign ph_load_full = phase_cycles(phase, STEP_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_cnt   <= '0;
      tick_o   <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (active_q) begin
        if (ph_cnt == '0) begin
          tick_o   <= 1'b1;
          active_q <= 1'b0;
        end else begin
          ph_cnt <= ph_cnt - 1'b1;
        end
      end else if (div_hit) begin
        active_q <= 1'b1;
        ph_cnt   <= PH_W'(ph_load_full);
      end
    end
  end

  // R9: a tick only comes out of a running phase countdown
  a_r9_tick_after_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !div_hit) |=> !tick_o);

  // R9: the tick lasts a single cycle
  a_r9_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R8: the divide count restarts after each divided pulse
  a_r8_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_hit |=> (div_cnt == 8'd0));
endmodule

// File: rtl/evseq_core.sv
module evseq_core #(
  parameter int DEPTH = 16,
  parameter int PW    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  trig_sel,
  input  logic                        src_sw,
  input  logic                        src_ext,
  input  logic                        src_cnt,
  input  logic                        src_line,
  input  logic                        recycle,
  input  logic [PW-1:0]               presc_m1,
  input  logic                        we,
  input  logic [$clog2(DEPTH)-1:0]    waddr,
  input  logic [evseq_pkg::TS_W-1:0]  wts,
  input  logic [evseq_pkg::CODE_W-1:0] wcode,
  output logic [evseq_pkg::CODE_W-1:0] code_o,
  output logic                        busy_o
);
  import evseq_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  seq_entry_t      mem [DEPTH];
  seq_entry_t      cur;
  logic            run_q;
  logic [AW-1:0]   ptr;
  logic [TS_W-1:0] seq_time;
  logic [PW-1:0]   pcnt;
  logic            trig;
  logic            due;
  logic            end_hit;
  logic            last;
  logic            ptick;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= '{ts: wts, code: wcode};
  end

  always_comb begin
    unique case (trig_src_e'(trig_sel))
      SRC_SW:   trig = src_sw;
      SRC_EXT:  trig = src_ext;
      SRC_CNT:  trig = src_cnt;
      SRC_LINE: trig = src_line;
      default:  trig = 1'b0;
    endcase
  end

  assign cur     = mem[ptr];
  assign due     = run_q && entry_due(seq_time, cur.ts);
  assign end_hit = due && (cur.code == CODE_END);
  assign last    = (ptr == LAST_ADDR);
  assign ptick   = (pcnt == presc_m1);
  assign busy_o  = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      ptr      <= '0;
      seq_time <= '0;
      pcnt     <= '0;
      code_o   <= CODE_NULL;
    end else begin
      code_o <= CODE_NULL;
      if (!run_q) begin
        if (trig) begin
          run_q    <= 1'b1;
          ptr      <= '0;
          seq_time <= '0;
          pcnt     <= '0;
        end
      end else if (end_hit) begin
        if (recycle) begin
          ptr      <= '0;
          seq_time <= '0;
          pcnt     <= '0;
        end else begin
          run_q <= 1'b0;
        end
      end else begin
        pcnt     <= ptick ? '0 : pcnt + 1'b1;
        seq_time <= seq_time + (ptick ? 1 : 0);
        if (due) begin
          code_o <= cur.code;
          if (last) begin
            if (recycle) begin
              ptr      <= '0;
              seq_time <= '0;
              pcnt     <= '0;
            end else begin
              run_q <= 1'b0;
            end
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
      end
    end
  end

  // R5: an end code without recycle stops the sequencer
  a_r5_stop_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && !recycle) |=> !busy_o);

  // R6: an end code with recycle restarts from entry 0 at time zero
  a_r6_recycle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (end_hit && recycle) |=> (busy_o && ptr == '0 && seq_time == '0));

  // R7: while running, time never steps back unless the list finishes
  a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !end_hit && !(due && last)) |=> (run_q && seq_time >= $past(seq_time)));

  // R4: the end code is never sent
  a_r4_no_end_out: assert property (@(posedge clk) disable iff (!rst_n)
    code_o != CODE_END);
endmodule

// File: rtl/evseq_merge.sv
module evseq_merge #(
  parameter int N = 2
) (
  input  logic [N*evseq_pkg::CODE_W-1:0] codes_i,
  output logic [evseq_pkg::CODE_W-1:0]   code_o
);
  import evseq_pkg::*;

  // Scan from the highest index down so that index 0 wins.
  always_comb begin
    code_o = CODE_NULL;
    for (int i = N - 1; i >= 0; i--) begin
      if (codes_i[i*CODE_W +: CODE_W] != CODE_NULL)
        code_o = codes_i[i*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/evseq_top.sv
module evseq_top #(
  parameter int          NSEQ        = 2,
  parameter int          DEPTH       = 16,
  parameter int          PW          = 16,
  parameter int unsigned STEP_CYCLES = 12500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_in,
  input  logic                       ext_trig,
  input  logic                       cnt_tick,
  input  logic [NSEQ-1:0]            sw_trig,
  input  logic [2*NSEQ-1:0]          trig_sel,
  input  logic [NSEQ-1:0]            recycle,
  input  logic [NSEQ*PW-1:0]         presc_m1,
  input  logic [7:0]                 ls_div_m1,
  input  logic [7:0]                 ls_phase,
  input  logic [NSEQ-1:0]            ram_we,
  input  logic [$clog2(DEPTH)-1:0]   ram_addr,
  input  logic [31:0]                ram_ts,
  input  logic [7:0]                 ram_code,
  output logic [7:0]                 ev_code,
  output logic [NSEQ-1:0]            seq_busy,
  output logic                       line_sync_tick
);
  import evseq_pkg::*;

  logic [NSEQ*CODE_W-1:0] seq_codes;

  evseq_linesync #(.STEP_CYCLES(STEP_CYCLES)) u_linesync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_in(line_in),
    .div_m1 (ls_div_m1),
    .phase  (ls_phase),
    .tick_o (line_sync_tick)
  );

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    evseq_core #(.DEPTH(DEPTH), .PW(PW)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_sel(trig_sel[2*g +: 2]),
      .src_sw  (sw_trig[g]),
      .src_ext (ext_trig),
      .src_cnt (cnt_tick),
      .src_line(line_sync_tick),
      .recycle (recycle[g]),
      .presc_m1(presc_m1[g*PW +: PW]),
      .we      (ram_we[g]),
      .waddr   (ram_addr),
      .wts     (ram_ts),
      .wcode   (ram_code),
      .code_o  (seq_codes[g*CODE_W +: CODE_W]),
      .busy_o  (seq_busy[g])
    );
  end

  evseq_merge #(.N(NSEQ)) u_merge (
    .codes_i(seq_codes),
    .code_o (ev_code)
  );

  // R10: when sequencer 0 emits, its code is what leaves the block
  a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_codes[CODE_W-1:0] != CODE_NULL) |-> (ev_code == seq_codes[CODE_W-1:0]));
endmodule

// File: tb/evseq_top_bench.sv
`timescale 1ns/1ps
module evseq_top_bench;
  localparam int NSEQ = 2;
  localparam int DEPTH = 16;
  localparam int PW = 16;
  localparam int STEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0, ext_trig = 1'b0, cnt_tick = 1'b0;
  logic [1:0]  sw_trig = '0;
  logic [3:0]  trig_sel = '0;
  logic [1:0]  recycle = '0;
  logic [31:0] presc_m1 = '0;
  logic [7:0]  ls_div_m1 = '0, ls_phase = '0;
  logic [1:0]  ram_we = '0;
  logic [3:0]  ram_addr = '0;
  logic [31:0] ram_ts = '0;
  logic [7:0]  ram_code = '0;
  logic [7:0]  ev_code;
  logic [1:0]  seq_busy;
  logic        line_sync_tick;

  int checks = 0, fails = 0;
  int cyc = 0;
  int tick_count = 0, last_tick_cyc = -1;
  int last_code_cyc = -1;
  logic [7:0] last_code = '0;

  always #2.5 clk = ~clk;

  evseq_top #(.NSEQ(NSEQ), .DEPTH(DEPTH), .PW(PW), .STEP_CYCLES(STEP)) u_evseq_top (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .ext_trig(ext_trig), .cnt_tick(cnt_tick),
    .sw_trig(sw_trig), .trig_sel(trig_sel), .recycle(recycle), .presc_m1(presc_m1),
    .ls_div_m1(ls_div_m1), .ls_phase(ls_phase), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_ts(ram_ts), .ram_code(ram_code), .ev_code(ev_code), .seq_busy(seq_busy),
    .line_sync_tick(line_sync_tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (line_sync_tick) begin tick_count++; last_tick_cyc = cyc; end
    if (ev_code != 8'h00) begin last_code = ev_code; last_code_cyc = cyc; end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, actual, actual, expected, expected);
    end
  endtask

  task automatic wr(input int s, input int a, input int ts, input int code);
    @(negedge clk);
    ram_addr = 4'(a); ram_ts = 32'(ts); ram_code = 8'(code);
    ram_we = '0; ram_we[s] = 1'b1;
    @(negedge clk);
    ram_we = '0;
  endtask

  // Pulse a source for one edge (T); returns at the negedge after T.
  task automatic fire(input int src, input logic [1:0] mask);
    @(negedge clk);
    case (src)
      0: sw_trig = mask;
      1: ext_trig = 1'b1;
      default: cnt_tick = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    sw_trig = '0; ext_trig = 1'b0; cnt_tick = 1'b0;
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic line_pulse(output int e);
    @(negedge clk);
    line_in = 1'b1;
    e = cyc + 1;
    repeat (2) @(negedge clk);
    line_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // {sel[1:0], src[1:0], expect_start}
  localparam logic [4:0] VEC [8] = '{
    {2'd0, 2'd0, 1'b1}, {2'd0, 2'd1, 1'b0}, {2'd1, 2'd1, 1'b1}, {2'd1, 2'd2, 1'b0},
    {2'd2, 2'd2, 1'b1}, {2'd2, 2'd0, 1'b0}, {2'd3, 2'd0, 1'b0}, {2'd3, 2'd1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e1, e2, e3;
    int first_cyc, second_cyc;
    logic [7:0] first_code, second_code;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 code", ev_code, 0);
    check("R1 busy", seq_busy, 0);
    check("R1 tick", line_sync_tick, 0);

    // R2: source selection table
    wr(0, 0, 0, 8'h21);
    wr(0, 1, 0, 8'h7F);
    for (int v = 0; v < 8; v++) begin
      trig_sel[1:0] = VEC[v][4:3];
      fire(int'(VEC[v][2:1]), 2'b01);
      adv(1);
      check("R2 select", ev_code, VEC[v][0] ? 8'h21 : 8'h00);
      adv(3);
    end
    trig_sel = '0;

    // R3 timing, R7 retrigger ignored, R5 stop
    wr(0, 0, 2, 8'h31);
    wr(0, 1, 5, 8'h32);
    wr(0, 2, 5, 8'h7F);
    presc_m1[15:0] = 16'd2;
    fire(0, 2'b01);
    first_cyc = -1; second_cyc = -1; first_code = '0; second_code = '0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (ev_code != 0) begin
        if (first_cyc < 0) begin first_cyc = i; first_code = ev_code; end
        else if (second_cyc < 0) begin second_cyc = i; second_code = ev_code; end
      end
      if (i == 16) check("R5 busy before end", seq_busy[0], 1);
      if (i == 17) check("R5 busy after end", seq_busy[0], 0);
      if (i == 9)  sw_trig[0] = 1'b1;
      if (i == 10) sw_trig[0] = 1'b0;
    end
    check("R3 first slot", first_cyc, 7);
    check("R3 first code", first_code, 8'h31);
    check("R7 second slot", second_cyc, 16);
    check("R3 second code", second_code, 8'h32);
    adv(5);
    check("R5 stays idle", seq_busy[0], 0);
    check("R5 no output", ev_code, 0);
    presc_m1 = '0;

    // R4 null code
    wr(0, 0, 0, 8'h00);
    wr(0, 1, 1, 8'h44);
    wr(0, 2, 1, 8'h7F);
    fire(0, 2'b01);
    adv(1);
    check("R4 null slot", ev_code, 0);
    adv(1);
    check("R4 after null", ev_code, 8'h44);
    adv(4);

    // R6 recycle
    wr(0, 0, 0, 8'h51);
    wr(0, 1, 1, 8'h7F);
    recycle[0] = 1'b1;
    fire(0, 2'b01);
    adv(1);
    check("R6 first", ev_code, 8'h51);
    adv(1);
    check("R6 end slot", ev_code, 0);
    check("R6 busy held", seq_busy[0], 1);
    adv(1);
    check("R6 repeat", ev_code, 8'h51);
    recycle[0] = 1'b0;
    adv(5);
    check("R6 stop after clear", seq_busy[0], 0);

    // R10 priority, R12 independence
    wr(0, 0, 0, 8'h01);
    wr(0, 1, 0, 8'h7F);
    wr(1, 0, 0, 8'h0A);
    wr(1, 1, 1, 8'h0B);
    wr(1, 2, 1, 8'h7F);
    fire(0, 2'b11);
    adv(1);
    check("R10 seq0 wins", ev_code, 8'h01);
    adv(1);
    check("R10 seq1 later", ev_code, 8'h0B);
    adv(4);
    trig_sel = 4'b0100;
    fire(1, 2'b00);
    check("R12 only seq1 runs", seq_busy, 2'b10);
    adv(5);
    trig_sel = '0;

    // R8 divider, R9 phase
    wr(0, 0, 0, 8'h77);
    wr(0, 1, 0, 8'h7F);
    trig_sel = 4'b0011;
    ls_div_m1 = 8'd2;
    ls_phase = 8'd2;
    @(posedge clk); tick_count = 0; last_code_cyc = -1;
    line_pulse(e1);
    line_pulse(e2);
    adv(12);
    check("R8 no early tick", tick_count, 0);
    line_pulse(e3);
    adv(20);
    check("R8 one tick", tick_count, 1);
    check("R9 tick cycle", last_tick_cyc - e3, 3 + 2 * STEP);
    check("R2 line start code", last_code, 8'h77);
    check("R2 line start cycle", last_code_cyc - e3, 5 + 2 * STEP);
    trig_sel = '0;
    ls_div_m1 = 8'd0;
    ls_phase = 8'd0;
    @(posedge clk); tick_count = 0;
    line_pulse(e1);
    adv(10);
    check("R9 zero phase", last_tick_cyc - e1, 3);
    check("R8 ratio one", tick_count, 1);

    // R11 end of memory
    for (int a = 0; a < DEPTH; a++) wr(0, a, 0, 8'h60 + a);
    fire(0, 2'b01);
    adv(DEPTH);
    check("R11 last code", ev_code, 8'h6F);
    check("R11 stopped", seq_busy[0], 0);
    adv(3);
    check("R11 quiet", ev_code, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule